// File: doc/BRIEF.md
# Serial Flash Status Register and Write Protection Guard

This block keeps the status byte of a serial NOR flash and decides whether a status update, a program or an erase may proceed. The command decoder sends it one-cycle strobes for write-enable, write-disable and status-write (the status write carries its data byte). It also receives the level of the active-low write-protect pin and a busy flag from the program/erase engine. The block returns the status byte for a read-status command, a same-cycle accept flag for the status write, and a verdict on the address the decoder is about to program or erase.

The strobes carry no back-pressure and have no valid/ready pair. A strobe that arrives while the device is busy is dropped, and the decoder sees this only through the status byte. Block protection works in 64 KB blocks. A three-bit count N protects 2^(N-1) blocks, capped at the whole array. A direction bit chooses whether the protected blocks are counted from the highest address or from address zero. When the disable bit is set and the write-protect pin is low, the protection bits are frozen. They are released only when the pin goes high again.

Top module: `fl_status_guard`

## Requirements
- R1: After reset the status byte reads 0x00.
- R2: Status byte layout: bit 0 busy (WIP), bit 1 write-enable latch (WEL), bits 4:2 protect count, bit 5 direction (1 = from bottom), bit 6 always reads 0, bit 7 status-write disable (SRWD). An accepted write loads bits 7, 5 and 4:2 from the data byte and ignores the data in bits 6, 1 and 0.
- R3: A write-enable strobe sets WEL in the next cycle and a write-disable strobe clears it. Both are ignored while WIP is 1.
- R4: A status write without WEL is rejected: the accept flag is 0 and the status byte is unchanged.
- R5: With SRWD = 0 and WEL = 1, a status write is accepted at either level of the write-protect pin.
- R6: With SRWD = 1, write-protect high and WEL = 1, a status write is accepted.
- R7: With SRWD = 1 and write-protect low (after synchronisation), a status write is rejected even with WEL = 1, and bits 7:2 do not change. This holds whether the pin fell before or after SRWD was set.
- R8: Raising write-protect leaves the frozen state, and the next status write with WEL = 1 is accepted.
- R9: An accepted status write shows its new bits in the next cycle. WIP then reads 1 for exactly SRW_CYCLES cycles, and WIP and WEL drop to 0 together.
- R10: WIP reads 1 while the engine busy input is high and for one cycle after it falls. WEL reads 0 from the cycle in which that WIP ends.
- R11: With direction 0, a count N > 0 protects the top 2^(N-1) blocks. With direction 1 it protects the bottom 2^(N-1) blocks. N = 0 protects nothing, and counts beyond the array size protect every block.
- R12: The program/erase allow output is 1 exactly when WEL = 1, WIP = 0 and the presented address is not protected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wren_ev | input | 1 | Write-enable command strobe |
| wrdi_ev | input | 1 | Write-disable command strobe |
| wrsr_ev | input | 1 | Status-write command strobe |
| wrsr_byte | input | 8 | Data byte of the status write |
| wp_n | input | 1 | Write-protect pin level, active low, asynchronous |
| eng_busy | input | 1 | Program/erase engine running |
| pe_addr | input | ADDR_W | Byte address of the pending program or erase |
| status_byte | output | 8 | Status byte for read-status |
| wrsr_ok | output | 1 | Status write accepted this cycle |
| pe_prot | output | 1 | pe_addr lies in a protected block |
| pe_allow | output | 1 | Program/erase may start |

## Verification
A wrong lock state shows up at the first status write after a change of the write-protect pin. The accept flag is wrong in that same cycle, and the status byte is wrong in the next one. A wrong WEL or busy timer shows up in status bits 0 and 1 within one cycle. A timer with a wrong length shifts the cycle in which WIP falls. A wrong range decode shows up at once on pe_prot for an address just inside or just outside the protected boundary, so the bench probes both sides of each boundary.

// File: rtl/fl_sr_pkg.sv
package fl_sr_pkg;
  // status byte bit positions (read by the host, so fixed)
  localparam int SB_WIP  = 0;
  localparam int SB_WEL  = 1;
  localparam int SB_BP_L = 2;
  localparam int SB_TB   = 5;
  localparam int SB_SRWD = 7;

  typedef struct packed {
    logic       srwd;
    logic       tb;
    logic [2:0] bp;
  } nv_bits_t;

  function automatic nv_bits_t nv_from_byte(input logic [7:0] b);
    nv_bits_t n;
    n.srwd = b[SB_SRWD];
    n.tb   = b[SB_TB];
    n.bp   = b[SB_BP_L+2:SB_BP_L];
    return n;
  endfunction
endpackage

// File: rtl/fl_sr_hwlock.sv
module fl_sr_hwlock #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n,
  input  logic srwd,
  output logic hw_lock
);
  logic wp_s;

  generate
    if (SYNC_STAGES == 0) begin : g_direct
      assign wp_s = wp_n;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] chain;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[SYNC_STAGES-2 >= 0 ? SYNC_STAGES-2 : 0:0], wp_n} & {SYNC_STAGES{1'b1}};
      end
      assign wp_s = chain[SYNC_STAGES-1];
    end
  endgenerate

  // locked while SRWD is set and the pin (synchronised) is low
  assign hw_lock = srwd & ~wp_s;

  // R8
  lock_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hw_lock) && $stable(srwd)) |-> wp_s);
endmodule

// File: rtl/fl_sr_range.sv
module fl_sr_range #(
  parameter int BLK_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BLK_W-1:0] blk,
  input  logic [2:0]       bp,
  input  logic             tb,
  output logic             prot
);
  localparam int          NBLK     = 1 << BLK_W;
  localparam logic [BLK_W:0] NBLK_V = (BLK_W+1)'(NBLK);

  logic [BLK_W:0] cnt;
  logic [BLK_W:0] blk_x;

  always_comb begin
    if (bp == 3'd0)                 cnt = '0;
    else if (int'(bp) - 1 >= BLK_W) cnt = NBLK_V;
    else                            cnt = (BLK_W+1)'(1) << (bp - 3'd1);
  end

  assign blk_x = {1'b0, blk};
  assign prot  = tb ? (blk_x < cnt) : (blk_x >= (NBLK_V - cnt));

  // R11
  none_when_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bp == 3'd0) |-> !prot);
  // R11
  all_when_saturated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(bp) > BLK_W) |-> prot);
endmodule

// File: rtl/fl_sr_regs.sv
module fl_sr_regs
  import fl_sr_pkg::*;
#(
  parameter int SRW_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wren_ev,
  input  logic       wrdi_ev,
  input  logic       wrsr_ev,
  input  logic [7:0] wrsr_byte,
  input  logic       hw_lock,
  input  logic       eng_busy,
  output nv_bits_t   nv_q,
  output logic       wel_q,
  output logic       wip,
  output logic       accept
);
  localparam int TW = $clog2(SRW_CYCLES + 1);
  localparam logic [TW-1:0] LOAD = TW'(SRW_CYCLES);

  logic [TW-1:0] sr_cnt;
  logic          eng_q;
  logic          eng_end;
  logic          sr_end;

  assign wip     = (sr_cnt != '0) | eng_busy | eng_q;
  assign accept  = wrsr_ev & wel_q & ~wip & ~hw_lock;
  assign eng_end = eng_q & ~eng_busy;
  assign sr_end  = (sr_cnt == TW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q   <= '0;
      sr_cnt <= '0;
      eng_q  <= 1'b0;
    end else begin
      eng_q <= eng_busy;
      if (accept) begin
        nv_q   <= nv_from_byte(wrsr_byte);
        sr_cnt <= LOAD;
      end else if (sr_cnt != '0) begin
        sr_cnt <= sr_cnt - TW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                wel_q <= 1'b0;
    else if (sr_end | eng_end) wel_q <= 1'b0;
    else if (!wip) begin
      if (wrdi_ev)             wel_q <= 1'b0;
      else if (wren_ev)        wel_q <= 1'b1;
    end
  end

  // R9
  accept_starts_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (wip && wel_q));
  // R7
  hpm_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hw_lock |=> $stable(nv_q));
  // R10
  eng_end_clears_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(eng_busy) |=> !wel_q);
  // R3
  busy_holds_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eng_busy && sr_cnt == '0) |=> $stable(wel_q));
endmodule

// File: rtl/fl_status_guard.sv
module fl_status_guard
  import fl_sr_pkg::*;
#(
  parameter int ADDR_W      = 21,
  parameter int BLK_SHIFT   = 16,
  parameter int SRW_CYCLES  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wren_ev,
  input  logic              wrdi_ev,
  input  logic              wrsr_ev,
  input  logic [7:0]        wrsr_byte,
  input  logic              wp_n,
  input  logic              eng_busy,
  input  logic [ADDR_W-1:0] pe_addr,
  output logic [7:0]        status_byte,
  output logic              wrsr_ok,
  output logic              pe_prot,
  output logic              pe_allow
);
  localparam int BLK_W = ADDR_W - BLK_SHIFT;

  nv_bits_t         nv;
  logic             wel;
  logic             wip;
  logic             hw_lock;
  logic [BLK_W-1:0] blk;
  logic             unused_bits;

  assign blk         = pe_addr[ADDR_W-1:BLK_SHIFT];
  assign unused_bits = ^{pe_addr[BLK_SHIFT-1:0]};

  fl_sr_hwlock #(.SYNC_STAGES(SYNC_STAGES)) u_lock (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n), .srwd(nv.srwd), .hw_lock(hw_lock)
  );

  fl_sr_regs #(.SRW_CYCLES(SRW_CYCLES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wren_ev(wren_ev), .wrdi_ev(wrdi_ev),
    .wrsr_ev(wrsr_ev), .wrsr_byte(wrsr_byte), .hw_lock(hw_lock),
    .eng_busy(eng_busy), .nv_q(nv), .wel_q(wel), .wip(wip), .accept(wrsr_ok)
  );

  fl_sr_range #(.BLK_W(BLK_W)) u_range (
    .clk(clk), .rst_n(rst_n), .blk(blk), .bp(nv.bp), .tb(nv.tb), .prot(pe_prot)
  );

  always_comb begin
    status_byte                   = 8'h00;
    status_byte[SB_WIP]           = wip;
    status_byte[SB_WEL]           = wel;
    status_byte[SB_BP_L+2:SB_BP_L] = nv.bp;
    status_byte[SB_TB]            = nv.tb;
    status_byte[SB_SRWD]          = nv.srwd;
  end

  assign pe_allow = wel & ~wip & ~pe_prot;

  // R12
  allow_needs_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pe_allow |-> (status_byte[SB_WEL] && !eng_busy));
  // R4
  reject_without_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wrsr_ev && !status_byte[SB_WEL]) |=> $stable(status_byte[7:2]));
endmodule

// File: tb/test_fl_status_guard.sv
`timescale 1ns/1ps
module test_fl_status_guard;
  localparam int AW = 21;
  localparam int K_SR = 0, K_OK = 1, K_PROT = 2, K_ALLOW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wren_ev = 0, wrdi_ev = 0, wrsr_ev = 0;
  logic [7:0]    wrsr_byte = '0;
  logic          wp_n = 1'b1;
  logic          eng_busy = 1'b0;
  logic [AW-1:0] pe_addr = '0;
  logic [7:0]    status_byte;
  logic          wrsr_ok, pe_prot, pe_allow;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit finished = 0;

  typedef struct {
    int    due;
    int    kind;
    int    val;
    string tag;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  fl_status_guard i_fl_status_guard (
    .clk(clk), .rst_n(rst_n), .wren_ev(wren_ev), .wrdi_ev(wrdi_ev),
    .wrsr_ev(wrsr_ev), .wrsr_byte(wrsr_byte), .wp_n(wp_n), .eng_busy(eng_busy),
    .pe_addr(pe_addr), .status_byte(status_byte), .wrsr_ok(wrsr_ok),
    .pe_prot(pe_prot), .pe_allow(pe_allow)
  );

  task automatic check(string tag, int got, int exp);
    n_chk++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s: got 0x%0h expected 0x%0h (cycle %0d)", tag, got, exp, cyc);
    end
  endtask

  function automatic void push(int dly, int kind, int val, string tag);
    item_t it;
    it.due = cyc + dly; it.kind = kind; it.val = val; it.tag = tag;
    sb.push_back(it);
  endfunction

  // monitor: compares due items shortly after each falling edge
  always begin
    @(negedge clk);
    #2;
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].due == cyc) begin
        case (sb[i].kind)
          K_SR:    check(sb[i].tag, int'(status_byte), sb[i].val);
          K_OK:    check(sb[i].tag, int'(wrsr_ok), sb[i].val);
          K_PROT:  check(sb[i].tag, int'(pe_prot), sb[i].val);
          default: check(sb[i].tag, int'(pe_allow), sb[i].val);
        endcase
        sb.delete(i);
      end
    end
  end

  task automatic drv(bit en, bit dis, bit wr, logic [7:0] d);
    @(negedge clk); #1;
    wren_ev = en; wrdi_ev = dis; wrsr_ev = wr; wrsr_byte = d;
  endtask

  task automatic idle();
    drv(0, 0, 0, 8'h00);
  endtask

  task automatic set_addr(logic [AW-1:0] a);
    idle(); pe_addr = a;
  endtask

  task automatic set_wp(bit v);
    idle(); wp_n = v;
    repeat (3) idle();
  endtask

  task automatic wait_done();
    for (int i = 0; i < 40; i++) begin
      idle(); #1;
      if (!status_byte[0]) break;
    end
  endtask

  task automatic do_wr(logic [7:0] d, int exp_ok, string tag);
    drv(1, 0, 0, 8'h00);
    drv(0, 0, 1, d);
    push(0, K_OK, exp_ok, tag);
    if (exp_ok != 0) wait_done(); else idle();
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int n;
    repeat (3) idle();
    rst_n = 1'b1;
    idle();
    push(0, K_SR, 8'h00, "R1 reset");

    // R4: status write without WEL
    drv(0, 0, 1, 8'h9C);
    push(0, K_OK, 0, "R4 ok");
    idle();
    push(0, K_SR, 8'h00, "R4 unchanged");

    // R3: enable / disable
    drv(1, 0, 0, 0); idle();
    push(0, K_SR, 8'h02, "R3 wren");
    drv(0, 1, 0, 0); idle();
    push(0, K_SR, 8'h00, "R3 wrdi");

    // R5 with pin low, R9 timing, R3 ignored while busy
    set_wp(0);
    drv(1, 0, 0, 0);
    drv(0, 0, 1, 8'h0C);
    push(0, K_OK, 1, "R5 accept pin low");
    drv(0, 1, 0, 0);
    push(0, K_SR, 8'h0F, "R9 new bits next cycle");
    idle();
    push(0, K_SR, 8'h0F, "R3 wrdi ignored while busy");
    n = 2;
    for (int i = 0; i < 40; i++) begin
      idle(); #1;
      if (status_byte[0]) n++; else break;
    end
    check("R9 busy length", n, 8);
    check("R9 end clears WEL", int'(status_byte), 8'h0C);

    // R11: top 4 blocks with count 3, direction 0
    set_addr(21'h1C0000); push(0, K_PROT, 1, "R11 top edge in");
    set_addr(21'h1BFFFF); push(0, K_PROT, 0, "R11 top edge out");
    do_wr(8'h24, 1, "R11 set bottom 1");
    set_addr(21'h00FFFF); push(0, K_PROT, 1, "R11 bottom in");
    set_addr(21'h010000); push(0, K_PROT, 0, "R11 bottom out");
    do_wr(8'h1C, 1, "R11 set saturate");
    set_addr(21'h000000); push(0, K_PROT, 1, "R11 saturated");
    do_wr(8'h00, 1, "R11 set none");
    set_addr(21'h1FFFFF); push(0, K_PROT, 0, "R11 none");

    // R12 / R10: allow and engine busy
    drv(1, 0, 0, 0);
    set_addr(21'h100000);
    push(0, K_ALLOW, 1, "R12 allow");
    idle(); eng_busy = 1'b1;
    push(0, K_ALLOW, 0, "R12 blocked by busy");
    push(0, K_SR, 8'h03, "R10 busy shows WIP");
    idle(); idle();
    idle(); eng_busy = 1'b0;
    push(0, K_SR, 8'h03, "R10 WIP held one cycle");
    push(1, K_SR, 8'h00, "R10 WIP and WEL end");

    // R6 then R7 (pin falls after SRWD set)
    set_wp(1);
    do_wr(8'h80, 1, "R6 accept pin high");
    idle(); push(0, K_SR, 8'h80, "R6 value");
    set_wp(0);
    drv(1, 0, 0, 0);
    drv(0, 0, 1, 8'h00);
    push(0, K_OK, 0, "R7 rejected");
    idle();
    push(0, K_SR, 8'h82, "R7 frozen");

    // R8: release by raising pin
    set_wp(1);
    drv(0, 0, 1, 8'h00);
    push(0, K_OK, 1, "R8 accept after release");
    wait_done();
    check("R8 value", int'(status_byte), 8'h00);

    // R7 other order: pin low first, then SRWD set
    set_wp(0);
    do_wr(8'h80, 1, "R5 set SRWD pin low");
    drv(1, 0, 0, 0);
    drv(0, 0, 1, 8'h04);
    push(0, K_OK, 0, "R7 rejected other order");
    idle();
    push(0, K_SR, 8'h82, "R7 frozen other order");

    // R2: reserved/dynamic bits of data ignored
    set_wp(1);
    drv(0, 0, 1, 8'hFF);
    push(0, K_OK, 1, "R2 accept");
    wait_done();
    check("R2 layout", int'(status_byte), 8'hBC);

    // R12: protected address blocks allow
    drv(1, 0, 0, 0);
    set_addr(21'h000000);
    push(0, K_PROT, 1, "R12 prot");
    push(0, K_ALLOW, 0, "R12 blocked by protection");

    repeat (4) idle();
    finish_run();
  end
endmodule